// File: doc/BRIEF.md
# Segmented DAC Input Register and Decoder

This block is the digital front end of a 12-bit segmented digital-to-analog converter. A 12-bit data word enters through a two-stage register: the first stage is the combinational decode of the live input, the second is a register that loads on the rising clock edge. A mode input chooses clocked operation, where the switch lines move only on a rising edge, or transparent operation, where the input reaches the switch lines through logic alone, whatever the clock is doing.

The word is split into a 4-bit upper segment and an 8-bit binary part. The upper segment drives 15 equal-weight thermometer lines. The binary part drives eight lines in three scaled groups: two lines at full output scale, three lines scaled by 1/8, and three lines scaled by 1/64. Because decoding happens before the register, every switch line changes on the same edge in clocked mode, so the thermometer decode delay never shows at the output. The block gives the true switch vector, its bitwise complement, and two levels in LSB units. Each level is summed from the weights of the active lines, so the analog result can be checked without any analog model.

Top module: `dac_seg_front`

## Requirements
- R1: A rising edge with `rst_n` low clears the register to code 0. In clocked mode the outputs then show `sw_true` all zeros, `sw_comp` all ones, `lvl_comp` = 0 and `lvl_true` = 4095.
- R2: In clocked mode (`bypass` = 0), input changes while the clock is low leave every output unchanged until the next rising edge.
- R3: On each rising edge the register loads `din`. In clocked mode, input changes after that edge (clock high) have no effect until the next rising edge.
- R4: In transparent mode (`bypass` = 1), all outputs follow `din` through logic alone, with no clock edge needed.
- R5: Thermometer line k (k = 0..14) is `sw_true[8+k]`. It is 1 exactly when the unsigned value of code bits 11:8 is greater than k.
- R6: `sw_true[7:0]` equals code bits 7:0. Bits 7:6 are the full-scale pair (weights 128, 64), bits 5:3 the 1/8 group (weights 32, 16, 8) and bits 2:0 the 1/64 group (weights 4, 2, 1). Each thermometer line weighs 256.
- R7: `sw_comp` is always the bitwise inverse of `sw_true`.
- R8: `lvl_comp` is the sum of the weights of the active `sw_true` lines and equals the code. `lvl_true` is the sum over the active `sw_comp` lines and equals 4095 minus the code. The two levels always add to 4095.
- R9: Code 0x7FF gives `lvl_true` = 2048 and `lvl_comp` = 2047. Code 0x800 gives `lvl_true` = 2047 and `lvl_comp` = 2048. Code 0xFFF gives `lvl_true` = 0 and `lvl_comp` = 4095.
- R10: When `bypass` falls, the outputs show the word loaded at the most recent rising edge, even if that edge came during transparent mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock; the load happens on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to code 0 |
| bypass | input | 1 | 1 selects transparent mode, 0 selects clocked mode |
| din | input | 12 | Data word, bit 11 is the MSB |
| sw_true | output | 23 | Switch lines: [22:8] thermometer, [7:0] binary |
| sw_comp | output | 23 | Bitwise complement of `sw_true` |
| lvl_true | output | 12 | True-side magnitude in LSB units (4095 minus code) |
| lvl_comp | output | 12 | Complement-side magnitude in LSB units (code) |

## Verification
Two things can happen in the same cycle: the register loads on a rising edge, and the mode switches from transparent back to clocked. The bench sets up that collision by loading word A with `bypass` high, then presenting word B and lowering `bypass` together while the clock is low. The outputs must show A at once and B only after the following edge. A second overlap checked is a data change just after the edge with the clock still high: the outputs must stay on the captured word.

// File: rtl/dac_seg_pkg.sv
// Package: shared mode type and line-weight function for the segmented
// DAC front end. Assumes binary lines sit below the thermometer lines.
package dac_seg_pkg;

    // Register operating mode, encoded so that the mode pin maps directly.
    typedef enum logic {
        MODE_CLOCKED     = 1'b0,
        MODE_TRANSPARENT = 1'b1
    } reg_mode_e;

    // Weight in LSB units of switch line idx: binary lines weigh 2^idx,
    // every thermometer line weighs 2^bin_bits.
    function automatic int line_weight(input int idx, input int bin_bits);
        return (idx < bin_bits) ? (1 << idx) : (1 << bin_bits);
    endfunction

endpackage

// File: rtl/dac_therm_dec.sv
// Module: dac_therm_dec
// Turns the upper code segment into 2^SEG_BITS-1 equal-weight thermometer
// lines. Line k is high when the segment value exceeds k. Purely
// combinational; assumes SEG_BITS small (line count grows as 2^SEG_BITS).
module dac_therm_dec #(
    parameter int SEG_BITS = 4
) (
    input  logic [SEG_BITS-1:0]        seg,
    output logic [(2**SEG_BITS)-2:0]   therm
);
    localparam int N_LINES = (2**SEG_BITS) - 1;

    // One comparator per thermometer line.
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign therm[k] = (seg > SEG_BITS'(k));
    end

    // Shape check: lines form a solid run from line 0 and count the value.
    always_comb begin
        assert_therm_run_R5: assert ((({1'b0, therm} + 1) & {1'b0, therm}) == '0)
            else $error("thermometer lines not contiguous");
        assert_therm_count_R5: assert ($countones(therm) == int'(seg))
            else $error("thermometer line count differs from segment");
    end

endmodule

// File: rtl/dac_line_map.sv
// Module: dac_line_map
// Maps a data word onto the full switch vector: thermometer lines on top,
// binary lines below in three scaled groups (full, 1/8, 1/64). This is the
// input stage whose result the slave register captures. Assumes
// BIN_BITS >= 6 so that all three binary groups exist.
module dac_line_map #(
    parameter int THERM_BITS = 4,
    parameter int BIN_BITS   = 8
) (
    input  logic [THERM_BITS+BIN_BITS-1:0]          code,
    output logic [(2**THERM_BITS)-1+BIN_BITS-1:0]   lines
);
    localparam int CODE_W   = THERM_BITS + BIN_BITS;
    localparam int N_THERM  = (2**THERM_BITS) - 1;
    localparam int LO_W     = 3;                       // 1/64 group width
    localparam int MID_W    = 3;                       // 1/8 group width
    localparam int HI_W     = BIN_BITS - LO_W - MID_W; // full-scale pair

    logic [N_THERM-1:0] therm;
    logic [HI_W-1:0]    grp_hi;
    logic [MID_W-1:0]   grp_mid;
    logic [LO_W-1:0]    grp_lo;

    // Upper segment decode into equal-weight lines.
    dac_therm_dec #(.SEG_BITS(THERM_BITS)) u_therm (
        .seg   (code[CODE_W-1:BIN_BITS]),
        .therm (therm)
    );

    // Binary part split into its three scaled groups.
    assign grp_hi  = code[BIN_BITS-1:LO_W+MID_W];
    assign grp_mid = code[LO_W+MID_W-1:LO_W];
    assign grp_lo  = code[LO_W-1:0];

    // Assemble the switch vector, thermometer lines on top.
    assign lines = {therm, grp_hi, grp_mid, grp_lo};

endmodule

// File: rtl/dac_slave_reg.sv
// Module: dac_slave_reg
// Slave register for the decoded switch vector. Loads on every rising edge,
// synchronous active-low reset to RST_VAL. Assumes a single clock domain.
module dac_slave_reg #(
    parameter int         W       = 23,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Edge-triggered capture of the decoded lines.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/dac_level_sum.sv
// Module: dac_level_sum
// Sums the LSB weights of the active switch lines into a level. Used once
// on the true vector and once on the complement. Assumes LVL_W bits hold
// the sum of all weights.
module dac_level_sum
    import dac_seg_pkg::*;
#(
    parameter int BIN_BITS = 8,
    parameter int LINES    = 23,
    parameter int LVL_W    = 12
) (
    input  logic [LINES-1:0] lines,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] wt [LINES];

    // Constant weight per line, derived from its position.
    for (genvar j = 0; j < LINES; j++) begin : g_wt
        assign wt[j] = LVL_W'(line_weight(j, BIN_BITS));
    end

    // Weighted sum of the active lines.
    always_comb begin
        level = '0;
        for (int j = 0; j < LINES; j++) begin
            if (lines[j]) level = level + wt[j];
        end
    end

endmodule

// File: rtl/dac_seg_front.sv
// Module: dac_seg_front (top)
// Digital front end of a segmented DAC: decode the word, capture it in a
// slave register on the rising edge, or pass the decode straight through
// in transparent mode. Outputs true and complement switch vectors and the
// two levels in LSB units. Assumes synchronous active-low reset and that
// the transparent path is used only where decode skew is acceptable.
module dac_seg_front
    import dac_seg_pkg::*;
#(
    parameter int THERM_BITS = 4,
    parameter int BIN_BITS   = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       bypass,
    input  logic [THERM_BITS+BIN_BITS-1:0]             din,
    output logic [(2**THERM_BITS)-1+BIN_BITS-1:0]      sw_true,
    output logic [(2**THERM_BITS)-1+BIN_BITS-1:0]      sw_comp,
    output logic [THERM_BITS+BIN_BITS-1:0]             lvl_true,
    output logic [THERM_BITS+BIN_BITS-1:0]             lvl_comp
);
    localparam int CODE_W = THERM_BITS + BIN_BITS;
    localparam int LINES  = (2**THERM_BITS) - 1 + BIN_BITS;

    reg_mode_e          mode;
    logic [LINES-1:0]   master_lines;
    logic [LINES-1:0]   slave_lines;

    // Mode pin to typed mode.
    assign mode = reg_mode_e'(bypass);

    // Input stage: decode the live word.
    dac_line_map #(.THERM_BITS(THERM_BITS), .BIN_BITS(BIN_BITS)) u_map (
        .code  (din),
        .lines (master_lines)
    );

    // Output stage: all lines switch together on the edge.
    dac_slave_reg #(.W(LINES), .RST_VAL('0)) u_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (master_lines),
        .q     (slave_lines)
    );

    // Mode select: transparent passes the decode, clocked shows the slave.
    always_comb begin
        sw_true = (mode == MODE_TRANSPARENT) ? master_lines : slave_lines;
    end

    // Complementary switch vector.
    assign sw_comp = ~sw_true;

    // Complement-side level, summed from the true lines.
    dac_level_sum #(.BIN_BITS(BIN_BITS), .LINES(LINES), .LVL_W(CODE_W)) u_lvl_c (
        .lines (sw_true),
        .level (lvl_comp)
    );

    // True-side level, summed from the complement lines.
    dac_level_sum #(.BIN_BITS(BIN_BITS), .LINES(LINES), .LVL_W(CODE_W)) u_lvl_t (
        .lines (sw_comp),
        .level (lvl_true)
    );

    // Reset leaves code 0 visible in clocked mode.
    assert_reset_code0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !bypass) |-> (lvl_comp == '0 && sw_true == '0))
        else $error("outputs not at code 0 after reset");

    // Edge load: the next clocked view equals the word seen at the edge (also R10).
    assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (bypass || lvl_comp == $past(din)))
        else $error("clocked output differs from word at last edge");

    // Transparent mode shows the live word.
    assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (lvl_comp == din))
        else $error("transparent output differs from input");

    // The two levels always add to full scale.
    assert_level_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((CODE_W+1)'(lvl_true) + (CODE_W+1)'(lvl_comp)) == (CODE_W+1)'((2**CODE_W) - 1))
        else $error("levels do not add to full scale");

endmodule

// File: tb/sim_dac_seg_front.sv
// Bench for dac_seg_front: directed corner cases plus seeded random words
// in clocked, transparent and hold-after-edge patterns.
module sim_dac_seg_front;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bypass;
    logic [11:0] din;
    logic [22:0] sw_true, sw_comp;
    logic [11:0] lvl_true, lvl_comp;

    int n_tot = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dac_seg_front u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (bypass),
        .din      (din),
        .sw_true  (sw_true),
        .sw_comp  (sw_comp),
        .lvl_true (lvl_true),
        .lvl_comp (lvl_comp)
    );

    // Expected switch vector from R5 and R6.
    function automatic logic [22:0] exp_lines(input logic [11:0] c);
        logic [22:0] v;
        v[7:0] = c[7:0];
        for (int k = 0; k < 15; k++) v[8+k] = (int'(c[11:8]) > k);
        return v;
    endfunction

    // Full comparison of all outputs against code c (R5, R6, R7, R8).
    task automatic check_code(input string tag, input logic [11:0] c);
        logic [22:0] e;
        logic [11:0] et;
        e  = exp_lines(c);
        et = 12'(4095 - int'(c));
        n_tot++;
        if (sw_true !== e || sw_comp !== ~e || lvl_comp !== c || lvl_true !== et) begin
            n_bad++;
            $display("FAIL %s: true=%h comp=%h lt=%0d lc=%0d expected true=%h comp=%h lt=%0d lc=%0d",
                     tag, sw_true, sw_comp, lvl_true, lvl_comp, e, ~e, et, c);
        end
    endtask

    // Level-only comparison with literal expectations (R9).
    task automatic check_lvl(input string tag, input int et, input int ec);
        n_tot++;
        if (int'(lvl_true) != et || int'(lvl_comp) != ec) begin
            n_bad++;
            $display("FAIL %s: lt=%0d lc=%0d expected lt=%0d lc=%0d",
                     tag, lvl_true, lvl_comp, et, ec);
        end
    endtask

    // Present a word in clocked mode and check after the capturing edge.
    task automatic clocked_word(input string tag, input logic [11:0] c);
        @(negedge clk);
        bypass = 1'b0;
        din    = c;
        @(posedge clk);
        #1;
        check_code(tag, c);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        n_tot++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [11:0] c;
        seed   = $urandom(32'd20250);
        rst_n  = 1'b0;
        bypass = 1'b0;
        din    = 12'hABC;

        // R1: reset clears to code 0 even with a non-zero word present.
        repeat (3) @(posedge clk);
        #1;
        check_code("R1 reset", 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_code("R3 first load", 12'hABC);

        // R2: change while clock low is not visible before the edge.
        @(negedge clk);
        din = 12'h35A;
        #1;
        check_code("R2 hold low", 12'hABC);
        @(posedge clk);
        #1;
        check_code("R3 load", 12'h35A);

        // R3: change after the edge, clock still high, is ignored.
        #2;
        din = 12'hC0F;
        #1;
        check_code("R3 ignore after edge", 12'h35A);
        @(posedge clk);
        #1;
        check_code("R3 next edge", 12'hC0F);

        // R5/R6 corners: segment boundaries and binary group patterns.
        clocked_word("R5 seg0", 12'h0FF);
        clocked_word("R5 seg1", 12'h100);
        clocked_word("R5 seg15", 12'hF00);
        clocked_word("R6 hi pair", 12'h0C0);
        clocked_word("R6 mid group", 12'h038);
        clocked_word("R6 lo group", 12'h007);

        // R9: mid-scale and full-scale levels.
        clocked_word("R9 7FF", 12'h7FF);
        check_lvl("R9 7FF", 2048, 2047);
        clocked_word("R9 800", 12'h800);
        check_lvl("R9 800", 2047, 2048);
        clocked_word("R9 FFF", 12'hFFF);
        check_lvl("R9 FFF", 0, 4095);
        clocked_word("R8 zero", 12'h000);
        check_lvl("R8 zero", 4095, 0);

        // R4: transparent mode follows the input with no edge.
        @(negedge clk);
        bypass = 1'b1;
        din    = 12'h5A5;
        #1;
        check_code("R4 follow low", 12'h5A5);
        @(posedge clk);
        #2;
        din = 12'h96E;
        #1;
        check_code("R4 follow high", 12'h96E);

        // R10: a word loaded during transparent mode shows once clocked resumes.
        @(negedge clk);
        din = 12'h1E3;
        @(posedge clk);
        #1;
        check_code("R4 before switch", 12'h1E3);
        @(negedge clk);
        din    = 12'hE1C;
        bypass = 1'b0;
        #1;
        check_code("R10 return to clocked", 12'h1E3);
        @(posedge clk);
        #1;
        check_code("R10 following edge", 12'hE1C);

        // R1: reset in mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        din   = 12'h777;
        @(posedge clk);
        #1;
        check_code("R1 mid-run reset", 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // Seeded random mix of the three patterns.
        for (int i = 0; i < 400; i++) begin
            c = 12'($urandom);
            case ($urandom % 3)
                0: clocked_word("R3/R8 random clocked", c);
                1: begin
                    @(negedge clk);
                    bypass = 1'b1;
                    din    = c;
                    #1;
                    check_code("R4/R7 random transparent", c);
                end
                default: begin
                    @(negedge clk);
                    bypass = 1'b0;
                    din    = c;
                    @(posedge clk);
                    #2;
                    din = ~c;
                    #1;
                    check_code("R3/R5/R6 random hold", c);
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule